// File: doc/BRIEF.md
# Asynchronous Byte SRAM Cycle Controller

This block is a clocked master for a 32768-by-8 asynchronous static memory. A client offers one transfer at a time (a read or a write of one byte at one address) on a valid/ready request channel. The controller drives the memory address, the chip-select, output-enable and write-strobe lines, and the data bus drive enable. It holds each phase of the access for a number of clocks derived from nanosecond timing parameters and a clock-period parameter. When the access ends, it returns a one-cycle response that carries the read byte.

Back-pressure rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. The client may hold `req_valid` high with new fields at any time, and nothing is taken while `req_ready` is low. The response channel has no ready signal. `rsp_valid` is a single-cycle pulse, and the client must sample it when it appears. A new request can transfer in the same cycle that `rsp_valid` is high.

Every timing count is the time divided by `CLK_NS`, rounded up, with a floor of one clock. The memory data bus is split into an output byte, a drive enable and an input byte, so a pad cell can form the tri-state bus outside the block.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request transfers only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the response, and `req_valid` has no effect while `req_ready` is 0. Each accepted request gives exactly one `rsp_valid` pulse one cycle long, and responses come in request order.
- R3: A read (`req_we`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD = max(ceil(T_ACC_NS), ceil(T_OE_NS), ceil(T_CYC_NS)) clocks, starting the cycle after acceptance.
- R4: The byte on `mem_dq_in` in the last cycle of the read strobe appears on `rsp_rdata` with `rsp_valid`. `rsp_rdata` keeps that value until the next read completes, including across writes.
- R5: A write (`req_we`=1) holds `mem_ce_n`=0 and `mem_we_n`=0 for WP = max(ceil(T_WP_NS), ceil(T_DS_NS)) clocks, starting the cycle after acceptance, with `mem_oe_n`=1 the whole time.
- R6: `mem_dq_oe` is 1 with `mem_dq_out` = the request byte in every write-strobe cycle and every recovery cycle. It is 0 otherwise and never 1 while `mem_oe_n` is 0.
- R7: After the write strobe ends, all strobes stay 1 for REC = max(ceil(T_WR_NS), ceil(T_CYC_NS) - WP, 1) clocks. `rsp_valid` then pulses in the following cycle.
- R8: While `mem_ce_n` is 0, `mem_addr` equals the accepted request address and does not change.
- R9: Each count rounds a non-integer time ratio up, so every strobe phase lasts at least its nanosecond minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can transfer |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Byte to drive on the memory data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Byte from the memory data bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the controller with `CLK_NS`=8 and the 70 ns timing set. Every time ratio is then fractional: the read holds for 9 clocks, the write pulse for 7, and the recovery is padded from 1 to 2 clocks by the cycle-time rule. This exercises the rounding and the cycle-time padding together. A memory model returns a corrupted byte whenever the elapsed access time is too short. It also refuses a write pulse that is shorter than its minimum. Because of this, a controller that samples or releases one clock early produces wrong data at the scoreboard.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_WREC  = 2'd3
  } cyc_state_e;

  // nanoseconds to clocks, rounded up, never below one clock
  function automatic int unsigned ns_to_clk(input int unsigned t_ns,
                                            input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned rd_clks(input int unsigned clk_ns, input int unsigned t_acc,
                                          input int unsigned t_oe, input int unsigned t_cyc);
    return umax(umax(ns_to_clk(t_acc, clk_ns), ns_to_clk(t_oe, clk_ns)),
                ns_to_clk(t_cyc, clk_ns));
  endfunction

  function automatic int unsigned wp_clks(input int unsigned clk_ns, input int unsigned t_wp,
                                          input int unsigned t_ds);
    return umax(ns_to_clk(t_wp, clk_ns), ns_to_clk(t_ds, clk_ns));
  endfunction

  function automatic int unsigned rec_clks(input int unsigned clk_ns, input int unsigned t_wr,
                                           input int unsigned t_cyc, input int unsigned wp);
    int unsigned cyc;
    int unsigned pad;
    cyc = ns_to_clk(t_cyc, clk_ns);
    pad = (cyc > wp) ? (cyc - wp) : 1;
    return umax(umax(ns_to_clk(t_wr, clk_ns), pad), 1);
  endfunction

endpackage

// File: rtl/sram_span_timer.sv
module sram_span_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_cyc_fsm.sv
module sram_cyc_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned RD_CLKS   = 7,
  parameter int unsigned WP_CLKS   = 6,
  parameter int unsigned WREC_CLKS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             span_last,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             drive_nxt,
  output logic             span_load,
  output logic [CNT_W-1:0] span_val,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             rsp_valid
);

  cyc_state_e state_q, state_d;
  logic       rsp_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_READ) && span_last;

  always_comb begin
    state_d   = state_q;
    span_load = 1'b0;
    span_val  = '0;
    rsp_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          span_load = 1'b1;
          if (req_we) begin
            state_d  = ST_WRITE;
            span_val = CNT_W'(WP_CLKS);
          end else begin
            state_d  = ST_READ;
            span_val = CNT_W'(RD_CLKS);
          end
        end
      end
      ST_READ: begin
        if (span_last) begin
          state_d = ST_IDLE;
          rsp_d   = 1'b1;
        end
      end
      ST_WRITE: begin
        if (span_last) begin
          state_d   = ST_WREC;
          span_load = 1'b1;
          span_val  = CNT_W'(WREC_CLKS);
        end
      end
      ST_WREC: begin
        if (span_last) begin
          state_d = ST_IDLE;
          rsp_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign drive_nxt = (state_d == ST_WRITE) || (state_d == ST_WREC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      ce_n      <= !((state_d == ST_READ) || (state_d == ST_WRITE));
      oe_n      <= !(state_d == ST_READ);
      we_n      <= !(state_d == ST_WRITE);
      rsp_valid <= rsp_d;
    end
  end

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              drive_nxt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_dq_oe <= 1'b0;
    end else begin
      mem_dq_oe <= drive_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_ACC_NS = 70,
  parameter int unsigned T_OE_NS  = 35,
  parameter int unsigned T_CYC_NS = 70,
  parameter int unsigned T_WP_NS  = 55,
  parameter int unsigned T_DS_NS  = 30,
  parameter int unsigned T_WR_NS  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  localparam int unsigned RD_CLKS   = rd_clks(CLK_NS, T_ACC_NS, T_OE_NS, T_CYC_NS);
  localparam int unsigned WP_CLKS   = wp_clks(CLK_NS, T_WP_NS, T_DS_NS);
  localparam int unsigned WREC_CLKS = rec_clks(CLK_NS, T_WR_NS, T_CYC_NS, WP_CLKS);
  localparam int unsigned MAX_CLKS  = umax(umax(RD_CLKS, WP_CLKS), WREC_CLKS);
  localparam int unsigned CNT_W     = $clog2(MAX_CLKS + 1);

  logic             accept;
  logic             capture;
  logic             drive_nxt;
  logic             span_load;
  logic             span_last;
  logic [CNT_W-1:0] span_val;

  sram_span_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (span_load),
    .load_val (span_val),
    .last     (span_last)
  );

  sram_cyc_fsm #(
    .CNT_W     (CNT_W),
    .RD_CLKS   (RD_CLKS),
    .WP_CLKS   (WP_CLKS),
    .WREC_CLKS (WREC_CLKS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .span_last (span_last),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .drive_nxt (drive_nxt),
    .span_load (span_load),
    .span_val  (span_val),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .rsp_valid (rsp_valid)
  );

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .mem_dq_in  (mem_dq_in),
    .drive_nxt  (drive_nxt),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_ACC_NS = 70,
  parameter int unsigned T_OE_NS  = 35,
  parameter int unsigned T_CYC_NS = 70,
  parameter int unsigned T_WP_NS  = 55,
  parameter int unsigned T_DS_NS  = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n
);

  localparam int unsigned RD_N = rd_clks(CLK_NS, T_ACC_NS, T_OE_NS, T_CYC_NS);
  localparam int unsigned WP_N = wp_clks(CLK_NS, T_WP_NS, T_DS_NS);

  logic [15:0] we_lo_cnt;
  logic [15:0] oe_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= !mem_we_n ? we_lo_cnt + 16'd1 : 16'd0;
      oe_lo_cnt <= !mem_oe_n ? oe_lo_cnt + 16'd1 : 16'd0;
    end
  end

  a_r5_oe_idle_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  a_r6_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r6_drive_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r2_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 16'(WP_N)));

  a_r3_read_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo_cnt == 16'(RD_N)));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .CLK_NS   (CLK_NS),
  .T_ACC_NS (T_ACC_NS),
  .T_OE_NS  (T_OE_NS),
  .T_CYC_NS (T_CYC_NS),
  .T_WP_NS  (T_WP_NS),
  .T_DS_NS  (T_DS_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n)
);

// File: tb/sim_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_sram_cycle_ctrl;

  localparam int CLK_PERIOD = 8;
  localparam int T_ACC = 70, T_OE = 35, T_CYC = 70, T_WP = 55, T_DS = 30, T_WR = 5;

  function automatic int up(input int t);
    int c;
    c = (t + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int EXP_RD  = 9;  // ceil(70/8)=9, ceil(35/8)=5
  localparam int EXP_WP  = 7;  // ceil(55/8)=7, ceil(30/8)=4
  localparam int EXP_REC = 2;  // max(ceil(5/8)=1, 9-7=2)

  typedef struct packed {
    logic        we;
    logic [14:0] addr;
    logic [7:0]  data;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;
  logic        mem_ce_n, mem_oe_n, mem_we_n;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  item_t      exp_q[$];
  logic [7:0] gold [int];
  logic [7:0] mdl  [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_cycle_ctrl #(
    .CLK_NS(CLK_PERIOD), .T_ACC_NS(T_ACC), .T_OE_NS(T_OE), .T_CYC_NS(T_CYC),
    .T_WP_NS(T_WP), .T_DS_NS(T_DS), .T_WR_NS(T_WR)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- memory model with timing checks ----------------
  int   rd_cnt = 0;
  int   w_cnt = 0;
  logic [7:0]  w_dat;
  logic [14:0] w_adr;

  function automatic logic [7:0] mdl_rd(input logic [14:0] a);
    return mdl.exists(int'(a)) ? mdl[int'(a)] : 8'h00;
  endfunction

  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n &&
        rd_cnt * CLK_PERIOD >= T_ACC && rd_cnt * CLK_PERIOD >= T_OE)
      mem_dq_in = mdl_rd(mem_addr);
    else
      mem_dq_in = ~mdl_rd(mem_addr);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt = rd_cnt + 1;
      else rd_cnt = 0;
      if (mem_dq_oe && !mem_oe_n) check(1'b0, "R6 contention", 1, 0);
      if (!mem_ce_n && !mem_we_n) begin
        w_cnt = w_cnt + 1;
        w_dat = mem_dq_out;
        w_adr = mem_addr;
        if (!mem_dq_oe) check(1'b0, "R6 bus not driven in strobe", 0, 1);
      end else if (w_cnt > 0) begin
        // R9: pulse meets both pulse-width and data-setup minimums
        check(w_cnt * CLK_PERIOD >= T_WP && w_cnt * CLK_PERIOD >= T_DS,
              "R9 write pulse ns", w_cnt * CLK_PERIOD, T_WP);
        check(mem_dq_oe == 1'b1, "R6 data hold after strobe", mem_dq_oe, 1);
        mdl[int'(w_adr)] = w_dat;
        w_cnt = 0;
      end
    end
  end

  // ---------------- strobe shape monitor ----------------
  int  rd_run = 0, wr_run = 0, rec_run = 0;
  bit  rec_on = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && (rd_run == 0) && (wr_run == 0) && exp_q.size() > 0)
        check(mem_addr == exp_q[0].addr, "R8 address", mem_addr, exp_q[0].addr);
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_run++;
      else if (rd_run > 0) begin
        check(rd_run == EXP_RD, "R3 read strobe length", rd_run, EXP_RD);
        rd_run = 0;
      end
      if (!mem_ce_n && !mem_we_n) begin
        if (wr_run == 0) check(mem_oe_n == 1'b1, "R5 oe high in write", mem_oe_n, 1);
        wr_run++;
      end else if (wr_run > 0) begin
        check(wr_run == EXP_WP, "R5 write strobe length", wr_run, EXP_WP);
        wr_run = 0;
        rec_on = 1;
        rec_run = 0;
      end
      if (rec_on) begin
        if (rsp_valid) begin
          check(rec_run == EXP_REC, "R7 recovery length", rec_run, EXP_REC);
          check(mem_dq_oe == 1'b0, "R6 bus released", mem_dq_oe, 0);
          rec_on = 0;
        end else if (mem_ce_n && mem_we_n && mem_oe_n) begin
          rec_run++;
          check(mem_dq_oe == 1'b1, "R6 drive in recovery", mem_dq_oe, 1);
        end
      end
    end
  end

  // ---------------- scoreboard monitor ----------------
  logic [7:0] last_rd = 8'h00;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      item_t it;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", 1, 0);
      end else begin
        it = exp_q.pop_front();
        if (!it.we) begin
          check(rsp_rdata == it.data, "R4 read data", rsp_rdata, it.data);
          last_rd = it.data;
        end else begin
          check(rsp_rdata == last_rd, "R4 rdata held over write", rsp_rdata, last_rd);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input logic we, input logic [14:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    it.we = we;
    it.addr = a;
    if (we) begin
      gold[int'(a)] = d;
      it.data = d;
    end else begin
      it.data = gold.exists(int'(a)) ? gold[int'(a)] : 8'h00;
    end
    exp_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(!mem_dq_oe && !rsp_valid && req_ready, "R1 idle outputs",
          {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after release", req_ready, 1);

    // back-to-back writes, corner addresses (R5, R7, R8)
    issue(1'b1, 15'h0000, 8'h3C);
    issue(1'b1, 15'h7FFF, 8'hC3);
    issue(1'b1, 15'h1234, 8'h5A);
    // back-to-back reads (R3, R4, R9)
    issue(1'b0, 15'h0000, 8'h00);
    issue(1'b0, 15'h7FFF, 8'h00);
    issue(1'b0, 15'h1234, 8'h00);
    issue(1'b0, 15'h0555, 8'h00);
    go_idle();
    drain();

    // R2: request offered while busy has no effect
    issue(1'b1, 15'h0100, 8'h11);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 15'h0200; req_wdata = 8'h99;
    repeat (4) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R2 not ready while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    drain();
    issue(1'b0, 15'h0200, 8'h00);
    issue(1'b0, 15'h0100, 8'h00);
    go_idle();
    drain();

    // overwrite and alternating mix
    issue(1'b1, 15'h1234, 8'hFF);
    issue(1'b0, 15'h1234, 8'h00);
    for (int i = 0; i < 8; i++) begin
      issue(1'b1, 15'(i * 16'h0F0F), 8'(8'hA0 + i));
      if (i % 2 == 1) go_idle();
    end
    for (int i = 0; i < 8; i++) issue(1'b0, 15'(i * 16'h0F0F), 8'h00);
    go_idle();
    drain();
    check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule